// File: doc/BRIEF.md
# Core Standby and Power-Down Sequencer

This block sits beside one processor core and manages its low-power entry and exit. The core reports that it has executed a wait-for-interrupt or a wait-for-event instruction. The block then stops the core clock while the core stays powered and keeps all of its state. An interrupt ends a wait-for-interrupt standby. An event sent by another core ends a wait-for-event standby, which lets a core that is spinning on a lock sleep until the lock holder signals it.

Software can set a power-down enable bit before it executes wait-for-interrupt. When that bit is set and the power controller grants the request, the block runs an ordered hardware shutdown. It first asks for the L1 and L2 caches to be flushed, then asks for them to be turned off, and then asks for the core to leave coherence management. Once all three steps are done it reports that power may be removed. Each step is a request/acknowledge handshake with logic outside the block. A power-on reset request brings the block back to running from the powered-off state.

Top module: `core_lowpower_seq`

## Requirements
- R1: After the asynchronous reset, the state is RUN (code 0), the clock enable is 1, the power-safe output is 0, all three step requests are 0, and the power-down enable bit is 0.
- R2: The state codes on `state_o` are RUN=0, STANDBY_WFI=1, STANDBY_WFE=2, FLUSH=3, CACHE_OFF=4, COHERENCY_EXIT=5 and OFF=6. `core_clk_en_o` is registered. It falls one cycle after the state leaves RUN and rises at the same clock edge at which the state returns to RUN.
- R3: In RUN, a `wfi_i` pulse moves the block to STANDBY_WFI, and `wfi_i` takes priority over `wfe_i`. STANDBY_WFI returns to RUN only on `irq_i`. A power grant has no effect there while the enable bit is 0.
- R4: In RUN, a `wfe_i` pulse with no pending event moves the block to STANDBY_WFE. STANDBY_WFE returns to RUN on `sev_i` and ignores `irq_i`.
- R5: A `sev_i` pulse seen outside STANDBY_WFE is latched. The next `wfe_i` in RUN then keeps the block in RUN and clears the latch, so the WFE after that enters standby.
- R6: `pd_en_o` is loaded from `pd_wdata_i` when `pd_wr_i` is high, and only while the state is RUN. Writes in any other state are ignored.
- R7: In STANDBY_WFI, when the enable bit is 1 and `pwr_grant_i` is high, the next state is FLUSH. An `irq_i` in the same cycle wins and the block returns to RUN.
- R8: The shutdown runs FLUSH, then CACHE_OFF, then COHERENCY_EXIT, then OFF. The request of each step (`flush_req_o`, `cache_off_req_o`, `coh_exit_req_o`) is high only in its own state, at most one of them is high at a time, and each step advances only on its own acknowledge.
- R9: Once FLUSH has been entered, `irq_i` has no effect until OFF is left.
- R10: `pwr_safe_o` is high exactly while the state is OFF. OFF is left only on `por_i`, which returns the block to RUN and clears the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_i | input | 1 | Core executed wait-for-interrupt |
| wfe_i | input | 1 | Core executed wait-for-event |
| irq_i | input | 1 | Interrupt pending for this core |
| sev_i | input | 1 | Event sent by another core |
| pd_wr_i | input | 1 | Software write strobe for the power-down enable bit |
| pd_wdata_i | input | 1 | Value written to the power-down enable bit |
| pwr_grant_i | input | 1 | Power controller grants power-down |
| flush_ack_i | input | 1 | Cache flush complete |
| cache_off_ack_i | input | 1 | Caches disabled |
| coh_exit_ack_i | input | 1 | Core removed from coherence |
| por_i | input | 1 | Power-on reset request, acted on in OFF |
| core_clk_en_o | output | 1 | Core clock enable |
| flush_req_o | output | 1 | Request a flush of L1 and L2 |
| cache_off_req_o | output | 1 | Request cache disable |
| coh_exit_req_o | output | 1 | Request coherence exit |
| pwr_safe_o | output | 1 | Power may be removed |
| pd_en_o | output | 1 | Current power-down enable bit |
| state_o | output | 3 | Current state code, for debug |

## Verification
The state code on `state_o`, the registered clock enable, the three step requests and the power-safe output are all derived from the state register. A wrong transition therefore shows at the ports one clock edge after the input that caused it. A wrong wake source shows up as a standby that ends too early or never ends. A mis-ordered shutdown raises the wrong request, or raises two requests at once, in the first cycle of the bad state. A fault in the event latch stays hidden until the next WFE, which then returns at once when it should sleep, or sleeps when it should return.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN       = 3'd0,
    ST_WFI       = 3'd1,
    ST_WFE       = 3'd2,
    ST_FLUSH     = 3'd3,
    ST_CACHE_OFF = 3'd4,
    ST_COH_EXIT  = 3'd5,
    ST_OFF       = 3'd6
  } lps_state_e;
endpackage

// File: rtl/lps_event_reg.sv
// Latches a send-event that is not consumed by a waiting WFE.
module lps_event_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sev_i,
  input  logic in_wfe_i,
  input  logic consume_i,
  output logic pending_o
);
  logic ev_q;
  logic ev_d;

  always_comb begin
    ev_d = ev_q | (sev_i & ~in_wfe_i);
    if (consume_i) ev_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= 1'b0;
    else        ev_q <= ev_d;
  end

  assign pending_o = ev_q;
endmodule

// File: rtl/lps_pd_enable.sv
// Software power-down enable bit: writable only while running.
module lps_pd_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic in_run_i,
  input  logic clear_i,
  output logic pd_en_o
);
  logic en_q;
  logic load;
  logic en_d;

  assign load = clear_i | (wr_i & in_run_i);
  assign en_d = clear_i ? 1'b0 : wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= 1'b0;
    else if (load) en_q <= en_d;
  end

  assign pd_en_o = en_q;
endmodule

// File: rtl/lps_fsm.sv
// Standby / shutdown state machine.
module lps_fsm
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfi_i,
  input  logic       wfe_i,
  input  logic       irq_i,
  input  logic       sev_i,
  input  logic       ev_pending_i,
  input  logic       pd_en_i,
  input  logic       grant_i,
  input  logic       flush_ack_i,
  input  logic       cache_off_ack_i,
  input  logic       coh_exit_ack_i,
  input  logic       por_i,
  output lps_state_e state_q,
  output lps_state_e state_d,
  output logic       consume_o
);
  logic ev_any;
  assign ev_any = ev_pending_i | sev_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (wfi_i)                state_d = ST_WFI;
        else if (wfe_i && !ev_any) state_d = ST_WFE;
      end
      ST_WFI: begin
        if (irq_i)                   state_d = ST_RUN;
        else if (pd_en_i && grant_i) state_d = ST_FLUSH;
      end
      ST_WFE:       if (sev_i)           state_d = ST_RUN;
      ST_FLUSH:     if (flush_ack_i)     state_d = ST_CACHE_OFF;
      ST_CACHE_OFF: if (cache_off_ack_i) state_d = ST_COH_EXIT;
      ST_COH_EXIT:  if (coh_exit_ack_i)  state_d = ST_OFF;
      ST_OFF:       if (por_i)           state_d = ST_RUN;
      default:                           state_d = ST_RUN;
    endcase
  end

  assign consume_o = (state_q == ST_RUN) & wfe_i & ~wfi_i & ev_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/lps_clk_en.sv
// Registered core clock enable: drops a cycle after leaving RUN,
// rises on the same edge that re-enters RUN.
module lps_clk_en
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lps_state_e state_q,
  input  lps_state_e state_d,
  output logic       clk_en_o
);
  logic ce_q;
  logic ce_d;

  assign ce_d = (state_q == ST_RUN) | (state_d == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b1;
    else        ce_q <= ce_d;
  end

  assign clk_en_o = ce_q;
endmodule

// File: rtl/core_lowpower_seq.sv
module core_lowpower_seq
  import lps_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wfi_i,
  input  logic               wfe_i,
  input  logic               irq_i,
  input  logic               sev_i,
  input  logic               pd_wr_i,
  input  logic               pd_wdata_i,
  input  logic               pwr_grant_i,
  input  logic               flush_ack_i,
  input  logic               cache_off_ack_i,
  input  logic               coh_exit_ack_i,
  input  logic               por_i,
  output logic               core_clk_en_o,
  output logic               flush_req_o,
  output logic               cache_off_req_o,
  output logic               coh_exit_req_o,
  output logic               pwr_safe_o,
  output logic               pd_en_o,
  output logic [STATE_W-1:0] state_o
);
  lps_state_e st_q;
  lps_state_e st_d;
  logic       ev_pending;
  logic       ev_consume;
  logic       pd_en;

  lps_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .wfi_i           (wfi_i),
    .wfe_i           (wfe_i),
    .irq_i           (irq_i),
    .sev_i           (sev_i),
    .ev_pending_i    (ev_pending),
    .pd_en_i         (pd_en),
    .grant_i         (pwr_grant_i),
    .flush_ack_i     (flush_ack_i),
    .cache_off_ack_i (cache_off_ack_i),
    .coh_exit_ack_i  (coh_exit_ack_i),
    .por_i           (por_i),
    .state_q         (st_q),
    .state_d         (st_d),
    .consume_o       (ev_consume)
  );

  lps_event_reg u_ev (
    .clk       (clk),
    .rst_n     (rst_n),
    .sev_i     (sev_i),
    .in_wfe_i  (st_q == ST_WFE),
    .consume_i (ev_consume),
    .pending_o (ev_pending)
  );

  lps_pd_enable u_pd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (pd_wr_i),
    .wdata_i  (pd_wdata_i),
    .in_run_i (st_q == ST_RUN),
    .clear_i  ((st_q == ST_OFF) & por_i),
    .pd_en_o  (pd_en)
  );

  lps_clk_en u_ce (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (st_q),
    .state_d  (st_d),
    .clk_en_o (core_clk_en_o)
  );

  assign flush_req_o     = (st_q == ST_FLUSH);
  assign cache_off_req_o = (st_q == ST_CACHE_OFF);
  assign coh_exit_req_o  = (st_q == ST_COH_EXIT);
  assign pwr_safe_o      = (st_q == ST_OFF);
  assign pd_en_o         = pd_en;
  assign state_o         = st_q;
endmodule

// File: rtl/lps_checker.sv
module lps_checker
  import lps_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               irq_i,
  input logic               sev_i,
  input logic               flush_ack_i,
  input logic               por_i,
  input logic               core_clk_en_o,
  input logic               flush_req_o,
  input logic               cache_off_req_o,
  input logic               coh_exit_req_o,
  input logic               pwr_safe_o,
  input logic               pd_en_o,
  input logic [STATE_W-1:0] state_o
);
  // R8: at most one shutdown step requested at a time
  a_r8_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_req_o, cache_off_req_o, coh_exit_req_o}));

  // R8: flush step holds until its acknowledge
  a_r8_flush_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_FLUSH && !flush_ack_i) |=> (state_o == ST_FLUSH));

  // R10: power-safe only in OFF
  a_r10_safe_in_off: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_safe_o == (state_o == ST_OFF));

  // R10: OFF is left only on power-on reset
  a_r10_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_OFF && !por_i) |=> (state_o == ST_OFF));

  // R2: clock stays gated through a continuing standby
  a_r2_gated_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_WFI && $past(state_o) == ST_WFI) |-> !core_clk_en_o);

  // R4: WFE standby holds without a send-event, regardless of interrupts
  a_r4_wfe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_WFE && !sev_i) |=> (state_o == ST_WFE));

  // R7: shutdown entered only from WFI standby with the enable bit set
  a_r7_flush_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_FLUSH && $past(state_o) != ST_FLUSH)
      |-> ($past(state_o) == ST_WFI && $past(pd_en_o) && !$past(irq_i)));
endmodule

bind core_lowpower_seq lps_checker u_lps_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .irq_i           (irq_i),
  .sev_i           (sev_i),
  .flush_ack_i     (flush_ack_i),
  .por_i           (por_i),
  .core_clk_en_o   (core_clk_en_o),
  .flush_req_o     (flush_req_o),
  .cache_off_req_o (cache_off_req_o),
  .coh_exit_req_o  (coh_exit_req_o),
  .pwr_safe_o      (pwr_safe_o),
  .pd_en_o         (pd_en_o),
  .state_o         (state_o)
);

// File: tb/tb_core_lowpower_seq.sv
`timescale 1ns/1ps
module tb_core_lowpower_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic wfi, wfe, irq, sev, pd_wr, pd_wdata, grant;
  logic fl_ack, co_ack, cx_ack, por;
  logic ce, fl_req, co_req, cx_req, safe, pden;
  logic [2:0] st;

  always #10 clk = ~clk; // 50 MHz

  core_lowpower_seq dut (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .irq_i(irq),
    .sev_i(sev), .pd_wr_i(pd_wr), .pd_wdata_i(pd_wdata),
    .pwr_grant_i(grant), .flush_ack_i(fl_ack), .cache_off_ack_i(co_ack),
    .coh_exit_ack_i(cx_ack), .por_i(por), .core_clk_en_o(ce),
    .flush_req_o(fl_req), .cache_off_req_o(co_req), .coh_exit_req_o(cx_req),
    .pwr_safe_o(safe), .pd_en_o(pden), .state_o(st)
  );

  typedef struct {
    int         due;
    string      tag;
    logic [2:0] st;
    logic       ce;
    logic       safe;
    logic [2:0] req;
    logic       pd;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input exp_t e);
    logic [2:0] req_act;
    req_act = {cx_req, co_req, fl_req};
    n_cmp++;
    if (st !== e.st || ce !== e.ce || safe !== e.safe ||
        req_act !== e.req || pden !== e.pd) begin
      n_bad++;
      $display("FAIL %s: st/ce/safe/req/pd actual %0d/%b/%b/%b/%b expected %0d/%b/%b/%b/%b",
               e.tag, st, ce, safe, req_act, pden, e.st, e.ce, e.safe, e.req, e.pd);
    end
  endtask

  // Monitor: compare items whose cycle has arrived
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      compare(q[0]);
      void'(q.pop_front());
    end
  end

  // Driver: inputs are already set; queue the result after the next edge
  task automatic tick(input string tag, input logic [2:0] s, input logic c,
                      input logic sf, input logic [2:0] rq, input logic p);
    exp_t e;
    e.due = cyc + 1; e.tag = tag; e.st = s; e.ce = c;
    e.safe = sf; e.req = rq; e.pd = p;
    q.push_back(e);
    @(negedge clk);
    wfi = 0; wfe = 0; irq = 0; sev = 0; pd_wr = 0; pd_wdata = 0;
    grant = 0; fl_ack = 0; co_ack = 0; cx_ack = 0; por = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end

  initial begin
    exp_t e0;
    rst_n = 0;
    wfi = 0; wfe = 0; irq = 0; sev = 0; pd_wr = 0; pd_wdata = 0;
    grant = 0; fl_ack = 0; co_ack = 0; cx_ack = 0; por = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    e0.due = 0; e0.tag = "R1 reset"; e0.st = 3'd0; e0.ce = 1;
    e0.safe = 0; e0.req = 3'b000; e0.pd = 0;
    compare(e0);

    // WFI standby, clock gating only
    wfi = 1;   tick("R3 wfi entry",             3'd1, 1, 0, 3'b000, 0);
               tick("R2 gated one cycle later", 3'd1, 0, 0, 3'b000, 0);
    grant = 1; tick("R3 grant without enable",  3'd1, 0, 0, 3'b000, 0);
    irq = 1;   tick("R2 irq wakes, clock on",   3'd0, 1, 0, 3'b000, 0);

    // WFE standby
    wfe = 1;   tick("R4 wfe entry",             3'd2, 1, 0, 3'b000, 0);
               tick("R2 wfe gated",             3'd2, 0, 0, 3'b000, 0);
    irq = 1;   tick("R4 irq ignored in wfe",    3'd2, 0, 0, 3'b000, 0);
    pd_wr = 1; pd_wdata = 1;
               tick("R6 write outside run",     3'd2, 0, 0, 3'b000, 0);
    sev = 1;   tick("R4 sev wakes",             3'd0, 1, 0, 3'b000, 0);

    // Event latch
    sev = 1;   tick("R5 sev latched in run",    3'd0, 1, 0, 3'b000, 0);
    wfe = 1;   tick("R5 wfe returns at once",   3'd0, 1, 0, 3'b000, 0);
    wfe = 1;   tick("R5 latch cleared",         3'd2, 1, 0, 3'b000, 0);
    sev = 1;   tick("R4 sev wakes again",       3'd0, 1, 0, 3'b000, 0);

    // Power-down
    pd_wr = 1; pd_wdata = 1;
               tick("R6 enable written",        3'd0, 1, 0, 3'b000, 1);
    wfi = 1; wfe = 1;
               tick("R3 wfi over wfe",          3'd1, 1, 0, 3'b000, 1);
    grant = 1; irq = 1;
               tick("R7 irq beats grant",       3'd0, 1, 0, 3'b000, 1);
    wfi = 1;   tick("R3 wfi again",             3'd1, 1, 0, 3'b000, 1);
    grant = 1; tick("R7 grant starts flush",    3'd3, 0, 0, 3'b001, 1);
    irq = 1;   tick("R9 irq ignored in flush",  3'd3, 0, 0, 3'b001, 1);
    fl_ack = 1; tick("R8 to cache off",         3'd4, 0, 0, 3'b010, 1);
    cx_ack = 1; irq = 1;
               tick("R8 foreign ack ignored",   3'd4, 0, 0, 3'b010, 1);
    co_ack = 1; tick("R8 to coherence exit",    3'd5, 0, 0, 3'b100, 1);
    cx_ack = 1; tick("R10 off, safe",           3'd6, 0, 1, 3'b000, 1);
    irq = 1; sev = 1;
               tick("R9 irq ignored in off",    3'd6, 0, 1, 3'b000, 1);
    por = 1;   tick("R10 por to run",           3'd0, 1, 0, 3'b000, 0);

    @(negedge clk);
    summary();
  end
endmodule